// File: doc/BRIEF.md
# Dual Limit Watchdog Comparator

This block watches a stream of signed conversion results on behalf of an acquisition sequencer. When the sequencer begins a watchdog instruction, it pulses a start strobe together with the index of that instruction. The block then takes the next two valid conversion results in order. It checks the first against limit one and the second against limit two. Each limit has its own direction bit, which chooses whether a result above the limit or below it counts as a violation. After the second result the block goes back to idle.

Each violating comparison produces a one-cycle event pulse, which feeds interrupt source 0 upstream. The violation is also logged in a sticky flag bank that holds one flag per limit for each instruction slot. Software reads the flag bank through a read strobe, and that read clears it. Interrupt masking and the converter itself sit outside this block.

Top module: `wd_dual_limit`

## Requirements
- R1: After reset the flag bank reads all zero and the event output is low.
- R2: A start strobe seen while idle latches the 3-bit instruction index and arms the block. The next valid result is compared with limit one, the valid result after that is compared with limit two, and the block then returns to idle.
- R3: When a limit's direction bit is 1, a violation is a result strictly greater than that limit. When the bit is 0, a violation is a result strictly less than it. Results and limits are compared as 13-bit two's complement numbers.
- R4: A result equal to the limit it is compared with is never a violation, whatever the direction bit.
- R5: The event output is high for exactly one cycle, the cycle after each violating comparison, and is low in every other cycle.
- R6: A violation against limit j (j=0 for limit one, j=1 for limit two) for instruction slot k sets flag bit 2*k+j. The bit is visible from the cycle after the comparison.
- R7: While the read strobe is high, the flag output shows the current flags. The whole bank is cleared at the clock edge that ends the read cycle.
- R8: A violation whose comparison falls in the same cycle as a read leaves its flag set after the clear.
- R9: A valid result that arrives while idle causes no event and changes no flag. A start strobe that arrives while armed is ignored, and the originally latched index is kept.
- R10: Flags are sticky. They accumulate across instructions until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Watchdog instruction begins |
| instr_idx_i | input | 3 | Index of the instruction being started |
| conv_valid_i | input | 1 | Conversion result strobe |
| conv_data_i | input | 13 | Signed conversion result |
| lim1_i | input | 13 | Signed limit one |
| lim2_i | input | 13 | Signed limit two |
| dir1_i | input | 1 | Limit one direction: 1 above, 0 below |
| dir2_i | input | 1 | Limit two direction: 1 above, 0 below |
| stat_rd_i | input | 1 | Flag bank read strobe (clears the bank) |
| stat_o | output | 16 | Flag bank, bit 2*k+j for slot k, limit j |
| event_o | output | 1 | Watchdog violation event pulse |

## Verification
The hardest situation to reach is a violation whose comparison lands in the very cycle of a read, because the set and the clear then act on the same edge. Random traffic almost never lines the two up. A directed case therefore raises the read strobe during the limit-two result. Two more directed cases cover the other awkward situations: a start strobe repeated while the block is armed, and results placed exactly on a limit, one above it and one below it, including the extremes of the 13-bit range. Random instructions then draw results that cluster around the limits, so that both directions and both strict edges are visited many times.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LIM1 = 2'd1,
      PH_LIM2 = 2'd2
   } wdc_phase_e;

   localparam int WDC_NLIM = 2;
endpackage

// File: rtl/wdc_seq_fsm.sv
module wdc_seq_fsm
   import wdc_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [IDX_W-1:0]             idx_i,
   input  logic                         valid_i,
   output wdc_phase_e                   phase_o,
   output logic [IDX_W-1:0]             idx_o,
   output logic [WDC_NLIM-1:0]          cmp_en_o
);
   wdc_phase_e          phase_q, phase_d;
   logic [IDX_W-1:0]    idx_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: if (start_i) phase_d = PH_LIM1;
         PH_LIM1: if (valid_i) phase_d = PH_LIM2;
         PH_LIM2: if (valid_i) phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_IDLE && start_i) idx_q <= idx_i;
      end
   end

   assign cmp_en_o[0] = valid_i && (phase_q == PH_LIM1);
   assign cmp_en_o[1] = valid_i && (phase_q == PH_LIM2);
   assign phase_o     = phase_q;
   assign idx_o       = idx_q;

   // R2
   lim2_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_LIM2 && valid_i) |=> (phase_q == PH_IDLE));
   // R9
   idx_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(idx_q));
   // R2
   one_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmp_en_o));
endmodule

// File: rtl/wdc_thresh_cmp.sv
module wdc_thresh_cmp #(
   parameter int DATA_W     = 13,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] lim_i,
   input  logic              dir_i,
   output logic              viol_o
);
   logic above, below;

   generate
      if (SIGNED_CMP) begin : g_signed
         assign above = $signed(data_i) > $signed(lim_i);
         assign below = $signed(data_i) < $signed(lim_i);
      end else begin : g_unsigned
         assign above = data_i > lim_i;
         assign below = data_i < lim_i;
      end
   endgenerate

   assign viol_o = en_i && (dir_i ? above : below);

   // R4
   equal_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_i == lim_i) |-> !viol_o);
endmodule

// File: rtl/wdc_flag_bank.sv
module wdc_flag_bank
   import wdc_pkg::*;
#(
   parameter int SLOTS    = 8,
   parameter int IDX_W    = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WDC_NLIM-1:0]       set_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic                      rd_i,
   output logic [WDC_NLIM*SLOTS-1:0] flags_o
);
   localparam int NBITS = WDC_NLIM * SLOTS;

   logic [NBITS-1:0] flags_q, set_vec;

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      for (genvar j = 0; j < WDC_NLIM; j++) begin : g_lim
         assign set_vec[WDC_NLIM*k+j] = set_i[j] && (idx_i == IDX_W'(k));
      end
   end

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (!rst_n)    flags_q <= '0;
            else if (rd_i) flags_q <= set_vec;
            else           flags_q <= flags_q | set_vec;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (!rst_n)    flags_q <= '0;
            else if (rd_i) flags_q <= '0;
            else           flags_q <= flags_q | set_vec;
         end
      end
   endgenerate

   assign flags_o = flags_q;

   // R7
   rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && set_i == '0) |=> (flags_q == '0));
   // R10
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
   // R6
   rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ~$past(flags_q)) != '0) |-> ($past(set_i) != '0));
endmodule

// File: rtl/wd_dual_limit.sv
module wd_dual_limit
   import wdc_pkg::*;
#(
   parameter int DATA_W     = 13,
   parameter int SLOTS      = 8,
   parameter bit SIGNED_CMP = 1'b1,
   parameter bit SET_WINS   = 1'b1,
   localparam int IDX_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int STAT_W    = WDC_NLIM * SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  instr_idx_i,
   input  logic              conv_valid_i,
   input  logic [DATA_W-1:0] conv_data_i,
   input  logic [DATA_W-1:0] lim1_i,
   input  logic [DATA_W-1:0] lim2_i,
   input  logic              dir1_i,
   input  logic              dir2_i,
   input  logic              stat_rd_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              event_o
);
   generate
      if (DATA_W < 2)              begin : g_bad_w   $error("DATA_W must be at least 2");  end
      if (SLOTS < 2)               begin : g_bad_s   $error("SLOTS must be at least 2");   end
      if ((1 << IDX_W) != SLOTS)   begin : g_bad_p2  $error("SLOTS must be a power of 2"); end
   endgenerate

   wdc_phase_e              phase;
   logic [IDX_W-1:0]        idx_q;
   logic [WDC_NLIM-1:0]     cmp_en, viol;
   logic [DATA_W-1:0]       lim_arr [WDC_NLIM];
   logic                    dir_arr [WDC_NLIM];
   logic                    event_q;

   assign lim_arr[0] = lim1_i;
   assign lim_arr[1] = lim2_i;
   assign dir_arr[0] = dir1_i;
   assign dir_arr[1] = dir2_i;

   wdc_seq_fsm #(.IDX_W(IDX_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .idx_i    (instr_idx_i),
      .valid_i  (conv_valid_i),
      .phase_o  (phase),
      .idx_o    (idx_q),
      .cmp_en_o (cmp_en)
   );

   for (genvar j = 0; j < WDC_NLIM; j++) begin : g_cmp
      wdc_thresh_cmp #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) cmp_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_i   (cmp_en[j]),
         .data_i (conv_data_i),
         .lim_i  (lim_arr[j]),
         .dir_i  (dir_arr[j]),
         .viol_o (viol[j])
      );
   end

   wdc_flag_bank #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SET_WINS(SET_WINS)) flags_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (viol),
      .idx_i   (idx_q),
      .rd_i    (stat_rd_i),
      .flags_o (stat_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) event_q <= 1'b0;
      else        event_q <= |viol;
   end

   assign event_o = event_q;

   // R5
   event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> $past(conv_valid_i && phase != PH_IDLE));
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |=> !event_o);
   // R6
   event_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> (stat_o != '0));
endmodule

// File: tb/wd_dual_limit_tb_top.sv
module wd_dual_limit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i, conv_valid_i, dir1_i, dir2_i, stat_rd_i;
   logic [2:0]  instr_idx_i;
   logic [12:0] conv_data_i, lim1_i, lim2_i;
   logic [15:0] stat_o;
   logic        event_o;

   int          n_chk = 0, n_fail = 0, cyc = 0;
   logic [15:0] exp_stat = '0;

   always #2.5 clk = ~clk;

   wd_dual_limit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_idx_i(instr_idx_i),
      .conv_valid_i(conv_valid_i), .conv_data_i(conv_data_i),
      .lim1_i(lim1_i), .lim2_i(lim2_i), .dir1_i(dir1_i), .dir2_i(dir2_i),
      .stat_rd_i(stat_rd_i), .stat_o(stat_o), .event_o(event_o)
   );

   function automatic bit viol_f(int d, int l, bit dir);
      return dir ? (d > l) : (d < l);
   endfunction

   function automatic int clamp13(int v);
      if (v > 4095)  return 4095;
      if (v < -4096) return -4096;
      return v;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_start(int idx);
      start_i = 1'b1; instr_idx_i = 3'(idx);
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
      chk(event_o == 1'b0, "R5", event_o, 0);
   endtask

   // slot: instruction index latched; which: 0 limit one, 1 limit two, -1 idle
   task automatic do_conv(int d, int which, int slot, bit rd);
      bit v;
      v = 1'b0;
      conv_valid_i = 1'b1; conv_data_i = 13'(d); stat_rd_i = rd;
      if (which == 0) v = viol_f(d, $signed(lim1_i), dir1_i);
      if (which == 1) v = viol_f(d, $signed(lim2_i), dir2_i);
      if (rd) chk(stat_o == exp_stat, "R7", stat_o, exp_stat);
      @(posedge clk); @(negedge clk);
      conv_valid_i = 1'b0; stat_rd_i = 1'b0;
      if (rd) exp_stat = '0;
      if (v) exp_stat[2*slot+which] = 1'b1;
      chk(event_o == v, (which < 0) ? "R9" : "R3/R5", event_o, v);
      chk(stat_o == exp_stat, rd ? "R8" : "R6", stat_o, exp_stat);
      @(posedge clk); @(negedge clk);
      chk(event_o == 1'b0, "R5", event_o, 0);
   endtask

   task automatic do_read();
      stat_rd_i = 1'b1;
      chk(stat_o == exp_stat, "R7/R10", stat_o, exp_stat);
      @(posedge clk); @(negedge clk);
      stat_rd_i = 1'b0; exp_stat = '0;
      chk(stat_o == 16'h0, "R7", stat_o, 0);
   endtask

   task automatic set_lims(int l1, int l2, bit d1, bit d2);
      lim1_i = 13'(l1); lim2_i = 13'(l2); dir1_i = d1; dir2_i = d2;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; start_i = 0; conv_valid_i = 0; stat_rd_i = 0;
      instr_idx_i = 0; conv_data_i = 0;
      set_lims(0, 0, 1'b1, 1'b1);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1
      chk(stat_o == 16'h0, "R1", stat_o, 0);
      chk(event_o == 1'b0, "R1", event_o, 0);

      // R9: valid while idle ignored
      set_lims(-5, 5, 1'b0, 1'b1);
      do_conv(-100, -1, 0, 1'b0);

      // R2, R3: limit one below, limit two above; both trip (two pulses)
      do_start(3);
      do_conv(-6, 0, 3, 1'b0);
      do_conv(6, 1, 3, 1'b0);
      chk(stat_o == 16'h00C0, "R6", stat_o, 16'h00C0);

      // R4: exact equality at extremes of range
      set_lims(-4096, 4095, 1'b0, 1'b1);
      do_start(5);
      do_conv(-4096, 0, 5, 1'b0);
      do_conv(4095, 1, 5, 1'b0);
      set_lims(-4096, 4095, 1'b1, 1'b0);
      do_start(6);
      do_conv(-4095, 0, 6, 1'b0);
      do_conv(4094, 1, 6, 1'b0);
      chk(stat_o[15:12] == 4'b0011, "R3", stat_o[15:12], 3);

      // R9: start while armed is ignored, index kept
      set_lims(0, 0, 1'b1, 1'b1);
      do_start(1);
      do_start(7);
      do_conv(10, 0, 1, 1'b0);
      do_conv(-10, 1, 1, 1'b0);
      chk(stat_o[15:14] == 2'b00, "R9", stat_o[15:14], 0);

      // R10 then R7
      do_read();

      // R8: violation coinciding with read survives
      set_lims(100, -100, 1'b1, 1'b0);
      do_start(2);
      do_conv(101, 0, 2, 1'b0);
      do_conv(-101, 1, 2, 1'b1);
      chk(stat_o == 16'h0020, "R8", stat_o, 16'h0020);
      do_read();

      // random instructions
      for (int op = 0; op < 400; op++) begin
         int l1, l2, idx, d;
         l1 = clamp13(int'($urandom_range(0, 8191)) - 4096);
         l2 = clamp13(int'($urandom_range(0, 8191)) - 4096);
         set_lims(l1, l2, 1'($urandom), 1'($urandom));
         idx = $urandom_range(0, 7);
         if ($urandom_range(0, 9) == 0) do_conv(int'($urandom_range(0, 8191)) - 4096, -1, 0, 1'b0);
         do_start(idx);
         for (int s = 0; s < 2; s++) begin
            int l;
            l = (s == 0) ? l1 : l2;
            case ($urandom_range(0, 3))
               0: d = l;
               1: d = clamp13(l + 1);
               2: d = clamp13(l - 1);
               default: d = int'($urandom_range(0, 8191)) - 4096;
            endcase
            do_conv(d, s, idx, ($urandom_range(0, 15) == 0));
         end
         if ($urandom_range(0, 5) == 0) do_read();
      end
      do_read();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule